// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit corrects the result of a preceding binary add or subtract so that it reads as decimal again. It takes a 16-bit accumulator pair, given as a high byte and a low byte, along with the carry and half-carry flags that the binary operation produced. It applies one of four corrections: unpacked (one digit per byte, ASCII style) after addition, unpacked after subtraction, packed BCD (two digits per byte) after addition, and packed BCD after subtraction. It returns the corrected pair together with updated carry, half-carry, zero, sign and parity flags.

A request is made by pulsing `start_i` with the operation code and operands valid in the same cycle. A two-state controller handles each request. In `ST_IDLE`, a start takes transition `T_ACCEPT`: the corrected values are registered and the controller moves to `ST_DONE`. `ST_DONE` asserts `done_o` for one cycle and always returns to `ST_IDLE` through transition `T_RETIRE`. The outputs hold their values until the next accepted request. The binary add or subtract that comes first, and the overflow flag, belong to the neighbouring datapath.

Top module: `dec_adj_unit`

## Requirements
- R1: A synchronous reset (`rst`=1 at a clock edge) clears every output to 0, including `done_o`, and puts the controller in `ST_IDLE`.
- R2: A `start_i` seen at a clock edge while `done_o` is low registers the corrected outputs at that edge. `done_o` is then high for exactly one cycle.
- R3: A `start_i` seen while `done_o` is high is ignored. `done_o` falls at the next edge, and all data and flag outputs keep the values of the previous request.
- R4: Operation code 2'b00 is unpacked adjust after addition. If the low nibble of the low byte is above 9 or `af_i` is set, the low byte becomes (low+6) with its top nibble cleared, the high byte is incremented by one, and AF=CF=1. Otherwise only the top nibble of the low byte is cleared, the high byte passes unchanged, and AF=CF=0. Example: 0071h with AF=1 gives 0107h.
- R5: Operation code 2'b01 is unpacked adjust after subtraction. It uses the same condition as R4, but subtracts 6 from the low byte and 1 from the high byte, then clears the top nibble of the low byte. The flags follow the same rule as R4. Example: 00FFh with AF=1 gives FF09h.
- R6: Operation code 2'b10 is packed adjust after addition. If the low nibble is above 9 or `af_i` is set, 06h is added and AF=1; otherwise AF=0. Example: 7Bh gives 81h.
- R7: For code 2'b10, if the original low byte is above 99h or `cf_i` is set, a further 60h is added and CF=1; otherwise CF=0.
- R8: Operation code 2'b11 is packed adjust after subtraction. It mirrors R6 and R7: 06h is subtracted under the low condition (which sets AF), and 60h under the high condition (which sets CF). Both conditions are judged on the original byte. Example: 5Bh gives 55h.
- R9: The packed operations (codes 2'b10 and 2'b11) pass the high byte through unchanged.
- R10: For every operation, ZF is 1 when the corrected low byte is zero, SF is its bit 7, and PF is 1 when the byte has an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation code (see R4 to R8) |
| acc_hi_i | input | 8 | Accumulator high byte |
| acc_lo_i | input | 8 | Accumulator low byte |
| cf_i | input | 1 | Incoming carry/borrow flag |
| af_i | input | 1 | Incoming half-carry flag |
| acc_hi_o | output | 8 | Corrected high byte |
| acc_lo_o | output | 8 | Corrected low byte |
| cf_o | output | 1 | Carry flag result |
| af_o | output | 1 | Half-carry flag result |
| zf_o | output | 1 | Zero flag result |
| sf_o | output | 1 | Sign flag result |
| pf_o | output | 1 | Parity flag result (even) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The controller is the only internal state. If it is stuck or mis-steered, the fault shows at the ports within one cycle of a start: `done_o` fails to rise, stays high for two cycles, or a start landing on `done_o` overwrites the held outputs. A wrong correction condition shows up as soon as a request's outputs are registered. Typical symptoms are a nibble 9/10 boundary or an AF-only case that is not adjusted, or a low byte of 99h versus 9Ah that lands on the wrong side of the high threshold. Each one appears as a wrong byte or flag in the cycle when `done_o` is high.

// File: rtl/dec_adj_pkg.sv
package dec_adj_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_UNP_ADD = 2'b00,
        OP_UNP_SUB = 2'b01,
        OP_PKD_ADD = 2'b10,
        OP_PKD_SUB = 2'b11
    } adj_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } adj_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              cf;
        logic              af;
    } adj_res_t;
endpackage

// File: rtl/dec_adj_unpacked.sv
module dec_adj_unpacked
    import dec_adj_pkg::*;
(
    input  logic              sub_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              af_i,
    output adj_res_t          res_o
);
    localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] LOW_FIX = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] ONE     = BYTE_W'(1);

    logic              need_fix;
    logic [BYTE_W-1:0] lo_fixed;

    always_comb begin
        need_fix = (lo_i[NIB_W-1:0] > NIB_MAX) || af_i;
        lo_fixed = lo_i;
        res_o.hi = hi_i;
        if (need_fix) begin
            lo_fixed = sub_i ? (lo_i - LOW_FIX) : (lo_i + LOW_FIX);
            res_o.hi = sub_i ? (hi_i - ONE) : (hi_i + ONE);
        end
        res_o.lo = {{(BYTE_W-NIB_W){1'b0}}, lo_fixed[NIB_W-1:0]};
        res_o.cf = need_fix;
        res_o.af = need_fix;
    end
endmodule

// File: rtl/dec_adj_packed.sv
module dec_adj_packed
    import dec_adj_pkg::*;
(
    input  logic              sub_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              cf_i,
    input  logic              af_i,
    output adj_res_t          res_o
);
    localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);
    localparam logic [BYTE_W-1:0] BYTE_MAX = BYTE_W'(8'h99);
    localparam logic [BYTE_W-1:0] LOW_FIX  = BYTE_W'(8'h06);
    localparam logic [BYTE_W-1:0] HIGH_FIX = BYTE_W'(8'h60);

    logic              low_need;
    logic              high_need;
    logic [BYTE_W-1:0] step1;
    logic [BYTE_W-1:0] step2;

    always_comb begin
        low_need  = (lo_i[NIB_W-1:0] > NIB_MAX) || af_i;
        high_need = (lo_i > BYTE_MAX) || cf_i;
        step1 = lo_i;
        if (low_need) begin
            step1 = sub_i ? (lo_i - LOW_FIX) : (lo_i + LOW_FIX);
        end
        step2 = step1;
        if (high_need) begin
            step2 = sub_i ? (step1 - HIGH_FIX) : (step1 + HIGH_FIX);
        end
        res_o.hi = hi_i;
        res_o.lo = step2;
        res_o.af = low_need;
        res_o.cf = high_need;
    end
endmodule

// File: rtl/dec_adj_flags.sv
module dec_adj_flags
    import dec_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] val_i,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o
);
    always_comb begin
        zf_o = (val_i == '0);
        sf_o = val_i[BYTE_W-1];
        pf_o = ~(^val_i);
    end
endmodule

// File: rtl/dec_adj_unit.sv
module dec_adj_unit
    import dec_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] acc_hi_i,
    input  logic [BYTE_W-1:0] acc_lo_i,
    input  logic              cf_i,
    input  logic              af_i,
    output logic [BYTE_W-1:0] acc_hi_o,
    output logic [BYTE_W-1:0] acc_lo_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o,
    output logic              done_o
);
    adj_state_e state_q, state_d;
    adj_res_t   unp_res, pkd_res, sel_res;
    adj_op_e    op;
    logic       accept;
    logic       zf_c, sf_c, pf_c;

    assign op = adj_op_e'(op_i);

    dec_adj_unpacked u_unp (
        .sub_i (op_i[0]),
        .hi_i  (acc_hi_i),
        .lo_i  (acc_lo_i),
        .af_i  (af_i),
        .res_o (unp_res)
    );

    dec_adj_packed u_pkd (
        .sub_i (op_i[0]),
        .hi_i  (acc_hi_i),
        .lo_i  (acc_lo_i),
        .cf_i  (cf_i),
        .af_i  (af_i),
        .res_o (pkd_res)
    );

    always_comb begin
        unique case (op)
            OP_UNP_ADD, OP_UNP_SUB: sel_res = unp_res;
            OP_PKD_ADD, OP_PKD_SUB: sel_res = pkd_res;
            default:                sel_res = unp_res;
        endcase
    end

    dec_adj_flags u_flg (
        .val_i (sel_res.lo),
        .zf_o  (zf_c),
        .sf_o  (sf_c),
        .pf_o  (pf_c)
    );

    // Next-state logic: T_ACCEPT and T_RETIRE
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi_o <= '0;
            acc_lo_o <= '0;
            cf_o     <= 1'b0;
            af_o     <= 1'b0;
            zf_o     <= 1'b0;
            sf_o     <= 1'b0;
            pf_o     <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= accept;
            if (accept) begin
                acc_hi_o <= sel_res.hi;
                acc_lo_o <= sel_res.lo;
                cf_o     <= sel_res.cf;
                af_o     <= sel_res.af;
                zf_o     <= zf_c;
                sf_o     <= sf_c;
                pf_o     <= pf_c;
            end
        end
    end

    // R2
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    start_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_o) |=> done_o);

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_i && !done_o) |=> ($stable(acc_hi_o) && $stable(acc_lo_o) && $stable(cf_o) && $stable(af_o)));

    // R4
    unp_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_o && !op_i[1]) |=> (acc_lo_o[BYTE_W-1:NIB_W] == '0 && cf_o == af_o));

    // R9
    pkd_hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !done_o && op_i[1]) |=> (acc_hi_o == $past(acc_hi_i)));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (zf_o == (acc_lo_o == '0)));
endmodule

// File: tb/dec_adj_unit_tb_top.sv
module dec_adj_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [1:0] op_i;
    logic [7:0] acc_hi_i, acc_lo_i;
    logic       cf_i, af_i;
    logic [7:0] acc_hi_o, acc_lo_o;
    logic       cf_o, af_o, zf_o, sf_o, pf_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dec_adj_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i), .cf_i(cf_i), .af_i(af_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .cf_o(cf_o), .af_o(af_o),
        .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o), .done_o(done_o)
    );

    // expected {hi, lo, cf, af, zf, sf, pf}
    function automatic logic [20:0] ref_model(input logic [1:0] op, input logic [7:0] hi,
                                              input logic [7:0] lo, input logic cf, input logic af);
        logic [7:0] h, l;
        logic c, a, lown, hign;
        h = hi; l = lo;
        lown = (lo[3:0] > 4'd9) || af;
        if (!op[1]) begin
            if (lown) begin
                l = op[0] ? lo - 8'd6 : lo + 8'd6;
                h = op[0] ? hi - 8'd1 : hi + 8'd1;
            end
            l = {4'h0, l[3:0]};
            c = lown; a = lown;
        end else begin
            hign = (lo > 8'h99) || cf;
            if (lown) l = op[0] ? l - 8'h06 : l + 8'h06;
            if (hign) l = op[0] ? l - 8'h60 : l + 8'h60;
            c = hign; a = lown;
        end
        return {h, l, c, a, (l == 8'h00), l[7], ~(^l)};
    endfunction

    function automatic logic [20:0] observed();
        return {acc_hi_o, acc_lo_o, cf_o, af_o, zf_o, sf_o, pf_o};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6/R7 R10";
            default: return "R8 R9";
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [7:0] hi, input logic [7:0] lo,
                          input logic cf, input logic af);
        logic [20:0] exp;
        exp = ref_model(op, hi, lo, cf, af);
        @(negedge clk);
        op_i = op; acc_hi_i = hi; acc_lo_i = lo; cf_i = cf; af_i = af; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(observed() == exp, tag_of(op), observed(), exp);
        check(done_o == 1'b1, "R2 done high", {20'd0, done_o}, 21'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R2 done one cycle", {20'd0, done_o}, 21'd0);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [20:0] held, e2;
        void'($urandom(32'd20240607));
        rst = 1'b1; start_i = 1'b0; op_i = 2'b00;
        acc_hi_i = 8'h00; acc_lo_i = 8'h00; cf_i = 1'b0; af_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({observed(), done_o} == 22'd0, "R1 reset", observed(), 21'd0);
        rst = 1'b0;

        // R4 directed: 38h+39h -> 0071, AF=1 -> 0107
        run_op(2'b00, 8'h00, 8'h71, 1'b0, 1'b1);
        check({acc_hi_o, acc_lo_o} == 16'h0107, "R4 example", {5'd0, acc_hi_o, acc_lo_o}, 21'h0107);
        run_op(2'b00, 8'h12, 8'h39, 1'b1, 1'b0); // R4 no fix
        run_op(2'b00, 8'hFF, 8'h0A, 1'b0, 1'b0); // R4 boundary 10, wrap hi
        // R5 directed: 00FF AF=1 -> FF09
        run_op(2'b01, 8'h00, 8'hFF, 1'b1, 1'b1);
        check({acc_hi_o, acc_lo_o} == 16'hFF09, "R5 example", {5'd0, acc_hi_o, acc_lo_o}, 21'h0FF09);
        // R6 directed 7B -> 81
        run_op(2'b10, 8'h3C, 8'h7B, 1'b0, 1'b0);
        check(acc_lo_o == 8'h81 && acc_hi_o == 8'h3C, "R6 example R9", {5'd0, acc_hi_o, acc_lo_o}, 21'h3C81);
        run_op(2'b10, 8'h00, 8'h99, 1'b0, 1'b0); // R7 threshold not met
        run_op(2'b10, 8'h00, 8'h9A, 1'b0, 1'b0); // R7 threshold met -> 00, ZF
        check(acc_lo_o == 8'h00 && cf_o && zf_o, "R7 R10 9A", {13'd0, acc_lo_o}, 21'h0);
        run_op(2'b10, 8'h00, 8'h12, 1'b1, 1'b1); // R7 via CF
        // R8 directed 5B -> 55
        run_op(2'b11, 8'hA5, 8'h5B, 1'b0, 1'b1);
        check(acc_lo_o == 8'h55, "R8 example", {13'd0, acc_lo_o}, 21'h55);
        run_op(2'b11, 8'h00, 8'h05, 1'b1, 1'b0); // R8 high via CF -> A5

        // R3: start held while done high
        @(negedge clk);
        op_i = 2'b10; acc_hi_i = 8'h11; acc_lo_i = 8'h7B; cf_i = 1'b0; af_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        held = observed();
        e2 = ref_model(2'b10, 8'h11, 8'h7B, 1'b0, 1'b0);
        check(held == e2, "R2 first of pair", held, e2);
        op_i = 2'b00; acc_hi_i = 8'h55; acc_lo_i = 8'h3F; cf_i = 1'b1; af_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R3 done falls", {20'd0, done_o}, 21'd0);
        check(observed() == held, "R3 outputs held", observed(), held);

        // random mix
        for (int i = 0; i < 400; i++) begin
            run_op(2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule